// File: doc/BRIEF.md
# Bus Traffic Performance Monitor

A small register-mapped monitor placed next to a memory-controller port. It keeps one cycle counter and four event counters. Each event counter has its own 3-bit source code, which picks read-data beats, write-data beats or both. The beats arrive as per-cycle strobes. Software starts and stops counting through a control register and clears the counters with self-clearing pulse bits. It enables each counter one at a time through a set-only enable register, and reads the results through a plain read/write port.

The last event counter is wider than the others by `EXT_W` bits, so it runs longer between wraps. Its value is read through two slots. The slot that belongs to the counter returns everything above the low `EXT_W` bits. The slot that follows it returns the low `EXT_W` bits. Software rebuilds the value as `(upper << EXT_W) | low`. Every counter wraps when it overflows and sets a sticky flag bit, which software clears by writing 1 to it.

Top module: `bus_traffic_monitor`

## Requirements
- R1: After synchronous reset every counter, enable bit, source code and flag reads as zero.
- R2: Control bit 0 (offset 0x0) is the global run bit, and writing 0 stops all counting. A counter advances only when the run bit and its own enable bit are both set. The enable bits are at offset 0x10: bit n for event counter n and bit 31 for the cycle counter. Writing 1 sets an enable bit, writing 0 leaves it unchanged, and a read returns the enable bits.
- R3: The cycle counter, read at 0x100, adds 1 on each clock edge where it is enabled.
- R4: The source code of event counter n is at 0x1000 + 0x100·n, in bits [2:0], and reads back as written. Code 5 adds 1 per read beat, code 6 adds 1 per write beat, and code 7 adds 1 per beat of either kind, so a cycle with both beats adds 2.
- R5: Any other code counts nothing. A counter whose code is 0 also reads as 0 at its slot or slots.
- R6: Control bit 1 clears the cycle counter and control bit 2 clears all event counters. Each clear acts at the edge of the write and takes priority over counting at that edge. Neither bit is stored, so both read back as 0.
- R7: Counters wrap to zero past their maximum and set a sticky flag at 0x50: bit 31 for the cycle counter and bit n for event counter n. Writing 1 clears a flag bit, but a wrap at the same edge keeps it set.
- R8: The counter of width `CNT_W` + `EXT_W` (the last one) returns its bits above `EXT_W` at 0x110 + 0x10·3 (0x140) and its low `EXT_W` bits at 0x150. Event counter n (n < 3) is read at 0x110 + 0x10·n.
- R9: Read data appears in the cycle after the read request and holds until the next request. Unmapped addresses read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rd_beat | input | 1 | Read-data beat seen this cycle |
| wr_beat | input | 1 | Write-data beat seen this cycle |

## Verification
A beat or an enabled cycle changes a counter at the clock edge where it is sampled. A write to the control, enable, flag or source registers takes effect at the edge of the write, so the run bit steers counting from the following edge, while a clear or flag write acts on that same edge. Read data is due one cycle after the request. The bench's behavioural model applies each stimulus at the same rising edge as the design. It compares the registered read data at every falling edge, tagged with the requirement of the read that produced it. This keeps every expected value aligned to its own cycle and never to a guessed delay.

// File: rtl/tmon_pkg.sv
package tmon_pkg;
  localparam int unsigned REG_AW  = 16;
  localparam int unsigned N_EVT   = 4;
  localparam int unsigned SEL_W   = 3;

  localparam logic [REG_AW-1:0] A_CTRL   = 16'h0000;
  localparam logic [REG_AW-1:0] A_ENSET  = 16'h0010;
  localparam logic [REG_AW-1:0] A_FLAG   = 16'h0050;
  localparam logic [REG_AW-1:0] A_CYC    = 16'h0100;
  localparam logic [REG_AW-1:0] A_EVC0   = 16'h0110;
  localparam logic [REG_AW-1:0] A_EVC_ST = 16'h0010;
  localparam logic [REG_AW-1:0] A_SEL0   = 16'h1000;
  localparam logic [REG_AW-1:0] A_SEL_ST = 16'h0100;

  localparam logic [SEL_W-1:0] SRC_RD   = 3'd5;
  localparam logic [SEL_W-1:0] SRC_WR   = 3'd6;
  localparam logic [SEL_W-1:0] SRC_BOTH = 3'd7;

  function automatic logic [REG_AW-1:0] evc_addr(int unsigned n);
    return A_EVC0 + REG_AW'(n) * A_EVC_ST;
  endfunction

  function automatic logic [REG_AW-1:0] sel_addr(int unsigned n);
    return A_SEL0 + REG_AW'(n) * A_SEL_ST;
  endfunction

  function automatic logic [1:0] beat_inc(logic [SEL_W-1:0] src, logic rd, logic wr);
    case (src)
      SRC_RD:   return {1'b0, rd};
      SRC_WR:   return {1'b0, wr};
      SRC_BOTH: return 2'({1'b0, rd}) + 2'({1'b0, wr});
      default:  return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/tmon_counter.sv
module tmon_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         adv,
  input  logic [1:0]   inc,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic [W:0] sum;
  assign sum  = {1'b0, cnt} + (W+1)'(inc);
  assign wrap = adv && !clr && sum[W];

  always_ff @(posedge clk) begin
    if (rst || clr)   cnt <= '0;
    else if (adv)     cnt <= sum[W-1:0];
  end

  // R6
  clr_prio_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !adv) |=> $stable(cnt));
  // R7
  wrap_low_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt < W'(2)));
endmodule

// File: rtl/tmon_regs.sv
module tmon_regs
  import tmon_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr,
  input  logic [REG_AW-1:0]           addr,
  input  logic [31:0]                 wdata,
  input  logic                        wrap_cyc,
  input  logic [N_EVT-1:0]            wrap_evt,
  output logic                        run,
  output logic                        en_cyc,
  output logic [N_EVT-1:0]            en_evt,
  output logic                        clr_cyc,
  output logic                        clr_evt,
  output logic                        flag_cyc,
  output logic [N_EVT-1:0]            flag_evt,
  output logic [N_EVT-1:0][SEL_W-1:0] src
);
  logic hit_ctrl, hit_en, hit_flag;
  assign hit_ctrl = wr && (addr == A_CTRL);
  assign hit_en   = wr && (addr == A_ENSET);
  assign hit_flag = wr && (addr == A_FLAG);

  assign clr_cyc = hit_ctrl && wdata[1];
  assign clr_evt = hit_ctrl && wdata[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      en_cyc   <= 1'b0;
      en_evt   <= '0;
      flag_cyc <= 1'b0;
      flag_evt <= '0;
    end else begin
      if (hit_ctrl) run <= wdata[0];
      if (hit_en) begin
        en_cyc <= en_cyc | wdata[31];
        en_evt <= en_evt | wdata[N_EVT-1:0];
      end
      flag_cyc <= (flag_cyc && !(hit_flag && wdata[31])) || wrap_cyc;
      flag_evt <= (flag_evt & ~(hit_flag ? wdata[N_EVT-1:0] : '0)) | wrap_evt;
    end
  end

  for (genvar n = 0; n < N_EVT; n++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst)                                src[n] <= '0;
      else if (wr && (addr == sel_addr(n)))   src[n] <= wdata[SEL_W-1:0];
    end
  end

  // R7
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    wrap_cyc |=> flag_cyc);
  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_cyc && !hit_flag) |=> flag_cyc);
  // R2
  run_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !hit_ctrl |=> $stable(run));
endmodule

// File: rtl/bus_traffic_monitor.sv
module bus_traffic_monitor
  import tmon_pkg::*;
#(
  parameter int unsigned CNT_W = 32,
  parameter int unsigned EXT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              rd_beat,
  input  logic              wr_beat
);
  localparam int unsigned WIDE_W = CNT_W + EXT_W;
  localparam int unsigned LAST   = N_EVT - 1;

  logic                        run, en_cyc, clr_cyc, clr_evt, flag_cyc, wrap_cyc;
  logic [N_EVT-1:0]            en_evt, flag_evt, wrap_evt;
  logic [N_EVT-1:0][SEL_W-1:0] src;
  logic [CNT_W-1:0]            cyc_cnt;
  logic [N_EVT-1:0][WIDE_W-1:0] evt_cnt;
  logic [31:0]                 rd_val;

  tmon_regs u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .wrap_cyc(wrap_cyc), .wrap_evt(wrap_evt), .run(run), .en_cyc(en_cyc),
    .en_evt(en_evt), .clr_cyc(clr_cyc), .clr_evt(clr_evt),
    .flag_cyc(flag_cyc), .flag_evt(flag_evt), .src(src)
  );

  tmon_counter #(.W(CNT_W)) u_cyc (
    .clk(clk), .rst(rst), .clr(clr_cyc), .adv(run && en_cyc), .inc(2'd1),
    .cnt(cyc_cnt), .wrap(wrap_cyc)
  );

  for (genvar n = 0; n < N_EVT; n++) begin : g_evt
    localparam int unsigned W = (n == LAST) ? WIDE_W : CNT_W;
    logic [W-1:0] c;
    tmon_counter #(.W(W)) u_ctr (
      .clk(clk), .rst(rst), .clr(clr_evt), .adv(run && en_evt[n]),
      .inc(beat_inc(src[n], rd_beat, wr_beat)), .cnt(c), .wrap(wrap_evt[n])
    );
    assign evt_cnt[n] = WIDE_W'(c);
  end

  always_comb begin
    rd_val = '0;
    if (reg_addr == A_CTRL)  rd_val = {31'd0, run};
    if (reg_addr == A_ENSET) rd_val = {en_cyc, 31'(en_evt)};
    if (reg_addr == A_FLAG)  rd_val = {flag_cyc, 31'(flag_evt)};
    if (reg_addr == A_CYC)   rd_val = 32'(cyc_cnt);
    for (int n = 0; n < N_EVT; n++) begin
      if (reg_addr == sel_addr(n)) rd_val = 32'(src[n]);
      if (reg_addr == evc_addr(n) && src[n] != '0)
        rd_val = (n == LAST) ? 32'(evt_cnt[n][WIDE_W-1:EXT_W]) : 32'(evt_cnt[n]);
    end
    if (reg_addr == evc_addr(N_EVT) && src[LAST] != '0)
      rd_val = 32'(evt_cnt[LAST][EXT_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_val;
  end

  // R5
  src_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_EVC0 && src[0] == '0) |=> (reg_rdata == '0));
  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 16'h0200) |=> (reg_rdata == '0));
  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

// File: tb/bus_traffic_monitor_tb.sv
module bus_traffic_monitor_tb;
  localparam int CW = 8;
  localparam int XW = 8;
  localparam longint M  = (64'd1 << CW) - 1;
  localparam longint M3 = (64'd1 << (CW + XW)) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, rd_beat = 0, wr_beat = 0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  always #10 clk = ~clk;

  bus_traffic_monitor #(.CNT_W(CW), .EXT_W(XW)) u_dut (.*);

  int checks = 0, fails = 0;
  bit armed = 0, done = 0;
  string cur_tag = "R9", exp_tag = "R9";

  longint m_cyc, m_evt[4];
  bit m_run, m_encyc, m_fcyc;
  bit [3:0] m_en, m_fevt;
  bit [2:0] m_src[4];
  logic [31:0] exp_rdata;

  function automatic longint step(bit [2:0] s, bit r, bit w);
    if (s == 5) return longint'(r);
    if (s == 6) return longint'(w);
    if (s == 7) return longint'(r) + longint'(w);
    return 0;
  endfunction

  function automatic logic [31:0] mread(logic [15:0] a);
    if (a == 16'h0000) return {31'd0, m_run};
    if (a == 16'h0010) return {m_encyc, 27'd0, m_en};
    if (a == 16'h0050) return {m_fcyc, 27'd0, m_fevt};
    if (a == 16'h0100) return 32'(m_cyc);
    for (int n = 0; n < 4; n++) begin
      if (a == 16'h1000 + 16'(n) * 16'h100) return 32'(m_src[n]);
      if (a == 16'h0110 + 16'(n) * 16'h10)
        return (m_src[n] == 0) ? 32'd0 : (n == 3 ? 32'(m_evt[3] >> XW) : 32'(m_evt[n]));
    end
    if (a == 16'h0150) return (m_src[3] == 0) ? 32'd0 : 32'(m_evt[3] & 255);
    return 32'd0;
  endfunction

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    if (rst) begin
      m_cyc = 0; m_run = 0; m_encyc = 0; m_fcyc = 0; m_en = 0; m_fevt = 0;
      exp_rdata = 0;
      for (int n = 0; n < 4; n++) begin m_evt[n] = 0; m_src[n] = 0; end
    end else begin
      bit cc, ce, nrun;
      bit [3:0] wr_ev;
      bit wr_c;
      if (reg_rd) begin exp_rdata = mread(reg_addr); exp_tag = cur_tag; end
      cc = reg_wr && reg_addr == 16'h0000 && reg_wdata[1];
      ce = reg_wr && reg_addr == 16'h0000 && reg_wdata[2];
      nrun = (reg_wr && reg_addr == 16'h0000) ? reg_wdata[0] : m_run;
      wr_c = 0; wr_ev = 0;
      if (cc) m_cyc = 0;
      else if (m_run && m_encyc) begin
        m_cyc = m_cyc + 1;
        if (m_cyc > M) begin m_cyc = m_cyc & M; wr_c = 1; end
      end
      for (int n = 0; n < 4; n++) begin
        longint lim;
        lim = (n == 3) ? M3 : M;
        if (ce) m_evt[n] = 0;
        else if (m_run && m_en[n]) begin
          m_evt[n] = m_evt[n] + step(m_src[n], rd_beat, wr_beat);
          if (m_evt[n] > lim) begin m_evt[n] = m_evt[n] & lim; wr_ev[n] = 1; end
        end
      end
      if (reg_wr && reg_addr == 16'h0050) begin
        if (reg_wdata[31]) m_fcyc = 0;
        m_fevt = m_fevt & ~reg_wdata[3:0];
      end
      m_fcyc = m_fcyc | wr_c;
      m_fevt = m_fevt | wr_ev;
      if (reg_wr && reg_addr == 16'h0010) begin
        m_encyc = m_encyc | reg_wdata[31];
        m_en = m_en | reg_wdata[3:0];
      end
      for (int n = 0; n < 4; n++)
        if (reg_wr && reg_addr == 16'h1000 + 16'(n) * 16'h100) m_src[n] = reg_wdata[2:0];
      m_run = nrun;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (armed && !done) begin
      checks++;
      if (reg_rdata !== exp_rdata) begin
        fails++;
        $display("FAIL %s model compare: rdata=%h expected=%h", exp_tag, reg_rdata, exp_rdata);
      end
    end
  end

  task automatic tick(input logic w, input logic r, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
  endtask

  task automatic wreg(input logic [15:0] a, input logic [31:0] d);
    tick(1, 0, a, d);
    tick(0, 0, a, 0);
  endtask

  task automatic rreg(input logic [15:0] a, input string tag);
    cur_tag = tag;
    tick(0, 1, a, 0);
    tick(0, 0, a, 0);
  endtask

  task automatic expect_rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    rreg(a, tag);
    checks++;
    if (reg_rdata !== e) begin
      fails++;
      $display("FAIL %s direct read %h: got=%h expected=%h", tag, a, reg_rdata, e);
    end
  endtask

  task automatic beats(input int n, input int pat);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (pat)
        0: begin rd_beat = (i % 2 == 0); wr_beat = (i % 3 == 0); end
        1: begin rd_beat = 1; wr_beat = 1; end
        2: begin rd_beat = 1; wr_beat = 0; end
        default: begin rd_beat = (i % 5 != 0); wr_beat = (i % 4 == 1); end
      endcase
    end
    @(negedge clk);
    rd_beat = 0; wr_beat = 0;
  endtask

  task automatic read_all(input string tag);
    for (int a = 0; a < 6; a++) rreg(16'h0100 + 16'(a) * 16'h10, tag);
    rreg(16'h0050, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: run did not finish, got=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;
    // R1 reset state
    expect_rd(16'h0000, 32'd0, "R1");
    expect_rd(16'h0010, 32'd0, "R1");
    expect_rd(16'h0050, 32'd0, "R1");
    expect_rd(16'h0100, 32'd0, "R1");
    expect_rd(16'h1300, 32'd0, "R1");
    // R4 source codes read back
    wreg(16'h1000, 5); wreg(16'h1100, 6); wreg(16'h1200, 7); wreg(16'h1300, 7);
    expect_rd(16'h1100, 32'd6, "R4");
    // R2 only counter 0 and cycle counter enabled
    wreg(16'h0010, 32'h8000_0001);
    expect_rd(16'h0010, 32'h8000_0001, "R2");
    wreg(16'h0000, 1);
    beats(10, 0);
    expect_rd(16'h0120, 32'd0, "R2");
    read_all("R2");
    // R2 write 0 leaves enable bits; then enable all
    wreg(16'h0010, 0);
    expect_rd(16'h0010, 32'h8000_0001, "R2");
    wreg(16'h0010, 32'h0000_000e);
    beats(20, 1);
    read_all("R4");
    beats(17, 3);
    read_all("R3");
    // R2 stop: counts freeze
    wreg(16'h0000, 0);
    beats(12, 1);
    read_all("R2");
    // R6 clear events while beats present, run kept
    wreg(16'h0000, 1);
    fork beats(6, 1); begin tick(1, 0, 16'h0000, 32'h5); tick(0, 0, 0, 0); end join
    expect_rd(16'h0000, 32'd1, "R6");
    read_all("R6");
    wreg(16'h0000, 32'h3);
    read_all("R6");
    // R5 code 0 reads zero, unknown code counts nothing
    beats(8, 0);
    wreg(16'h1200, 0); wreg(16'h1100, 3);
    expect_rd(16'h0130, 32'd0, "R5");
    beats(8, 1);
    read_all("R5");
    wreg(16'h1200, 7);
    read_all("R5");
    // R7 overflow of cycle counter and counter 0, W1C
    beats(300, 2);
    read_all("R7");
    wreg(16'h0050, 32'h8000_0001);
    rreg(16'h0050, "R7");
    // R7 clear and wrap on same edge: drive while counting
    for (int i = 0; i < 260; i++) tick(1, 0, 16'h0050, 32'h8000_000f);
    tick(0, 0, 0, 0);
    rreg(16'h0050, "R7");
    // R8 wide counter past its narrow range and through its own wrap
    beats(700, 1);
    read_all("R8");
    beats(33000, 1);
    read_all("R8");
    expect_rd(16'h0050, {1'b1, 27'd0, 4'b1101}, "R7");
    // R9 unmapped and hold
    expect_rd(16'h0200, 32'd0, "R9");
    rreg(16'h0100, "R9");
    repeat (4) tick(0, 0, 16'h0100, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule